// File: doc/BRIEF.md
# IPv4 Header Fast-Path Classifier and Rewriter

The block takes one 20-byte IPv4 header per cycle, together with the length of the frame that carried it, the egress MTU, the route-cache hit flag, a next-hop identifier and a flag that marks the destination as this router. It checks that the header is sane and decides whether the packet can stay on the fast path. It then produces a 3-bit disposition code and the outgoing header.

A forwarded packet leaves with its TTL reduced by one. Its header checksum is patched incrementally and is never recomputed or verified. Locally addressed packets and every punted packet leave with the header unchanged. The next-hop identifier travels alongside the header as a tag. Both sides use a valid/ready handshake. The pipeline has two register stages, so the fixed latency is two cycles and the throughput is one header per cycle.

Header bit layout: byte 0 of the header sits at `hdr_i[159:152]`, so:

| Field | Bits |
|---|---|
| version | `[159:156]` |
| IHL | `[155:152]` |
| total length | `[143:128]` |
| TTL | `[95:88]` |
| checksum | `[79:64]` |
| destination | `[31:0]` |

Top module: `ipv4_fastpath`

## Requirements
- R1: A header is malformed and gets disposition 2 if any of these holds: version is not 4, IHL is below 5, total length is below IHL×4, or total length exceeds `frame_len_i`. Its header is output unchanged.
- R2: A well-formed header with IHL above 5, meaning it carries options, gets disposition 3 with the header unchanged.
- R3: A destination whose top four bits are 1110 (multicast) gets disposition 5 with the header unchanged.
- R4: A header with `to_self_i` set gets disposition 1 (local delivery). The header is output unchanged, including the TTL and the checksum.
- R5: A non-local header with `route_hit_i` low gets disposition 6 with the header unchanged.
- R6: A non-local header whose TTL is 0 or 1 gets disposition 4 with the header unchanged.
- R7: A header whose total length exceeds `mtu_i` needs fragmentation and gets disposition 7 with the header unchanged.
- R8: Any other header is forwarded with disposition 0. The TTL is reduced by one. The checksum becomes the old checksum plus 0x0100, with the carry out of bit 15 added back into bit 0. All other bits are unchanged. The incoming checksum is never verified, so a wrong checksum is patched the same way.
- R9: When several conditions hold, the first in this order decides the disposition: malformed, options, multicast, local, route miss, TTL expiry, fragmentation, forward.
- R10: An accepted header appears on `valid_o` two cycles after acceptance, with `next_hop_o` equal to the identifier accepted with it. Back-to-back headers stream out on consecutive cycles.
- R11: While `valid_o` is high and `ready_i` is low, `ready_o` is low. The outputs hold their values until `ready_i` returns.
- R12: After reset, `valid_o` is low and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| valid_i | input | 1 | input header valid |
| ready_o | output | 1 | block can accept a header |
| hdr_i | input | 160 | incoming IPv4 header, byte 0 at MSBs |
| frame_len_i | input | 16 | received frame length in bytes |
| mtu_i | input | 16 | egress MTU in bytes |
| route_hit_i | input | 1 | route cache hit |
| to_self_i | input | 1 | destination is this router |
| next_hop_i | input | NH_W | next-hop identifier |
| valid_o | output | 1 | output valid |
| ready_i | input | 1 | downstream can take output |
| hdr_o | output | 160 | outgoing header |
| disp_o | output | 3 | disposition code (0 fwd, 1 local, 2..7 punt reasons) |
| next_hop_o | output | NH_W | next-hop tag |

## Verification
The checker watches every cycle for these properties:
- Every forwarded header carries version 4 with IHL 5, a non-zero TTL, a non-multicast destination and a length of at least 20.
- A stalled output holds still, and backpressure is propagated to `ready_o`.

Other behaviours can only be shown by the bench's scenarios:
- The exact checksum patch on both correct and corrupt checksums.
- The priority between overlapping punt conditions and the MTU and TTL boundaries.
- The two-cycle latency when headers stream back to back.

// File: rtl/ipv4_fp_pkg.sv
package ipv4_fp_pkg;
  localparam int HDR_W  = 160;
  localparam int LEN_W  = 16;
  localparam int MIN_IHL = 5;
  localparam logic [3:0] MCAST_NIB = 4'hE;

  typedef enum logic [2:0] {
    DISP_FWD     = 3'd0,
    DISP_LOCAL   = 3'd1,
    DISP_BADHDR  = 3'd2,
    DISP_OPTIONS = 3'd3,
    DISP_TTL     = 3'd4,
    DISP_MCAST   = 3'd5,
    DISP_MISS    = 3'd6,
    DISP_FRAG    = 3'd7
  } disp_e;
endpackage

// File: rtl/ipv4_fp_classify.sv
module ipv4_fp_classify
  import ipv4_fp_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [LEN_W-1:0] mtu_i,
  input  logic             route_hit_i,
  input  logic             to_self_i,
  output disp_e            disp_o
);
  logic [3:0]       ver, ihl;
  logic [LEN_W-1:0] tot_len, hdr_bytes;
  logic [7:0]       ttl;
  logic [3:0]       dst_nib;
  logic             malformed;

  assign ver       = hdr_i[159:156];
  assign ihl       = hdr_i[155:152];
  assign tot_len   = hdr_i[143:128];
  assign ttl       = hdr_i[95:88];
  assign dst_nib   = hdr_i[31:28];
  assign hdr_bytes = LEN_W'({ihl, 2'b00});

  assign malformed = (ver != 4'd4) || (ihl < 4'(MIN_IHL)) ||
                     (tot_len < hdr_bytes) || (tot_len > frame_len_i);

  always_comb begin
    if (malformed)                     disp_o = DISP_BADHDR;
    else if (ihl > 4'(MIN_IHL))        disp_o = DISP_OPTIONS;
    else if (dst_nib == MCAST_NIB)     disp_o = DISP_MCAST;
    else if (to_self_i)                disp_o = DISP_LOCAL;
    else if (!route_hit_i)             disp_o = DISP_MISS;
    else if (ttl <= 8'd1)              disp_o = DISP_TTL;
    else if (tot_len > mtu_i)          disp_o = DISP_FRAG;
    else                               disp_o = DISP_FWD;
  end
endmodule

// File: rtl/ipv4_fp_rewrite.sv
module ipv4_fp_rewrite
  import ipv4_fp_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  input  disp_e            disp_i,
  output logic [HDR_W-1:0] hdr_o
);
  logic [16:0] sum;
  logic [15:0] csum_new;

  // TTL word drops by 0x0100 => complemented sum rises by 0x0100, end-around carry
  assign sum      = {1'b0, hdr_i[79:64]} + 17'h00100;
  assign csum_new = sum[15:0] + {15'b0, sum[16]};

  always_comb begin
    hdr_o = hdr_i;
    if (disp_i == DISP_FWD) begin
      hdr_o[95:88] = hdr_i[95:88] - 8'd1;
      hdr_o[79:64] = csum_new;
    end
  end
endmodule

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath
  import ipv4_fp_pkg::*;
#(
  parameter int NH_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [159:0]     hdr_i,
  input  logic [15:0]      frame_len_i,
  input  logic [15:0]      mtu_i,
  input  logic             route_hit_i,
  input  logic             to_self_i,
  input  logic [NH_W-1:0]  next_hop_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [159:0]     hdr_o,
  output logic [2:0]       disp_o,
  output logic [NH_W-1:0]  next_hop_o
);
  logic             adv;
  disp_e            cls_disp, s1_disp;
  logic             s1_valid;
  logic [HDR_W-1:0] s1_hdr, rw_hdr;
  logic [NH_W-1:0]  s1_nh;

  assign adv     = !valid_o || ready_i;
  assign ready_o = adv;

  ipv4_fp_classify u_classify (
    .hdr_i       (hdr_i),
    .frame_len_i (frame_len_i),
    .mtu_i       (mtu_i),
    .route_hit_i (route_hit_i),
    .to_self_i   (to_self_i),
    .disp_o      (cls_disp)
  );

  ipv4_fp_rewrite u_rewrite (
    .hdr_i  (s1_hdr),
    .disp_i (s1_disp),
    .hdr_o  (rw_hdr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid   <= 1'b0;
      s1_hdr     <= '0;
      s1_disp    <= DISP_FWD;
      s1_nh      <= '0;
      valid_o    <= 1'b0;
      hdr_o      <= '0;
      disp_o     <= '0;
      next_hop_o <= '0;
    end else if (adv) begin
      s1_valid   <= valid_i;
      s1_hdr     <= hdr_i;
      s1_disp    <= cls_disp;
      s1_nh      <= next_hop_i;
      valid_o    <= s1_valid;
      hdr_o      <= rw_hdr;
      disp_o     <= s1_disp;
      next_hop_o <= s1_nh;
    end
  end
endmodule

// File: rtl/ipv4_fastpath_chk.sv
module ipv4_fastpath_chk #(
  parameter int NH_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ready_o,
  input logic            valid_o,
  input logic            ready_i,
  input logic [159:0]    hdr_o,
  input logic [2:0]      disp_o,
  input logic [NH_W-1:0] next_hop_o
);
  AST_FWD_PLAIN_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && disp_o == 3'd0 |-> hdr_o[159:152] == 8'h45); // R1
  AST_FWD_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && disp_o == 3'd0 |-> hdr_o[143:128] >= 16'd20); // R2
  AST_FWD_NO_MCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && disp_o == 3'd0 |-> hdr_o[31:28] != 4'hE); // R3
  AST_FWD_TTL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && disp_o == 3'd0 |-> hdr_o[95:88] != 8'd0); // R6
  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |-> !ready_o); // R11
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(hdr_o) && $stable(disp_o)
                            && $stable(next_hop_o)); // R11
endmodule

bind ipv4_fastpath ipv4_fastpath_chk #(.NH_W(NH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .valid_o    (valid_o),
  .ready_i    (ready_i),
  .hdr_o      (hdr_o),
  .disp_o     (disp_o),
  .next_hop_o (next_hop_o)
);

// File: tb/ipv4_fastpath_bench.sv
module ipv4_fastpath_bench;
  localparam int NH_W = 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0, ready_i = 1'b1;
  logic            ready_o, valid_o;
  logic [159:0]    hdr_i = '0, hdr_o;
  logic [15:0]     frame_len_i = '0, mtu_i = '0;
  logic            route_hit_i = 1'b0, to_self_i = 1'b0;
  logic [NH_W-1:0] next_hop_i = '0, next_hop_o;
  logic [2:0]      disp_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipv4_fastpath #(.NH_W(NH_W)) u_ipv4_fastpath (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .hdr_i(hdr_i), .frame_len_i(frame_len_i), .mtu_i(mtu_i),
    .route_hit_i(route_hit_i), .to_self_i(to_self_i), .next_hop_i(next_hop_i),
    .valid_o(valid_o), .ready_i(ready_i), .hdr_o(hdr_o), .disp_o(disp_o),
    .next_hop_o(next_hop_o));

  function automatic logic [15:0] csum(input logic [159:0] h);
    logic [31:0] s = 0;
    for (int i = 0; i < 10; i++) if (i != 5) s += 32'(h[159-16*i -: 16]);
    s = (s & 32'hFFFF) + (s >> 16);
    s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  function automatic logic [159:0] mk(input logic [3:0] ver, input logic [3:0] ihl,
      input logic [15:0] tot, input logic [7:0] ttl, input logic [31:0] dst);
    logic [159:0] h = {ver, ihl, 8'h00, tot, 16'h1234, 16'h4000, ttl, 8'd6,
                       16'h0000, 32'h0a000001, dst};
    h[79:64] = csum(h);
    return h;
  endfunction

  function automatic logic [159:0] fwd_exp(input logic [159:0] h);
    logic [159:0] r = h;
    r[95:88] = h[95:88] - 8'd1;
    r[79:64] = csum(r);
    return r;
  endfunction

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [159:0] h, input logic [15:0] fl, input logic [15:0] mtu,
      input logic hit, input logic self, input logic [NH_W-1:0] nh);
    valid_i = 1'b1; hdr_i = h; frame_len_i = fl; mtu_i = mtu;
    route_hit_i = hit; to_self_i = self; next_hop_i = nh;
  endtask

  task automatic run_one(input string req, input logic [159:0] h, input logic [15:0] fl,
      input logic [15:0] mtu, input logic hit, input logic self,
      input logic [2:0] exp_disp, input logic [159:0] exp_hdr);
    @(negedge clk); drive(h, fl, mtu, hit, self, 8'h5A);
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 160'(valid_o), 160'd1);
    chk({req, " disp"}, 160'(disp_o), 160'(exp_disp));
    chk({req, " hdr"}, hdr_o, exp_hdr);
  endtask

  localparam logic [31:0] UNI = 32'h0a000002;

  task automatic t_reset();
    chk("R12 valid_o", 160'(valid_o), 160'd0);
    chk("R12 ready_o", 160'(ready_o), 160'd1);
  endtask

  task automatic t_forward();
    logic [159:0] h = mk(4, 5, 100, 64, UNI);
    logic [159:0] c;
    run_one("R8 fwd", h, 100, 1500, 1, 0, 3'd0, fwd_exp(h));
    chk("R10 next_hop", 160'(next_hop_o), 160'h5A);
    h = mk(4, 5, 20, 2, 32'hc0a80101);
    run_one("R8 fwd ttl2", h, 64, 1500, 1, 0, 3'd0, fwd_exp(h));
    // corrupt checksum 0xFF00 -> 0x0001 after end-around carry
    c = h; c[79:64] = 16'hFF00;
    h = c; h[95:88] = 8'd1; h[79:64] = 16'h0001;
    run_one("R8 corrupt carry", c, 64, 1500, 1, 0, 3'd0, h);
    c[79:64] = 16'h1234;
    h[79:64] = 16'h1334;
    run_one("R8 corrupt plain", c, 64, 1500, 1, 0, 3'd0, h);
  endtask

  task automatic t_local();
    logic [159:0] h = mk(4, 5, 100, 64, UNI);
    run_one("R4 local", h, 100, 1500, 1, 1, 3'd1, h);
    h = mk(4, 5, 100, 1, UNI);
    run_one("R9 local before ttl", h, 100, 1500, 0, 1, 3'd1, h);
  endtask

  task automatic t_malformed();
    logic [159:0] h;
    h = mk(6, 5, 100, 64, UNI); run_one("R1 version", h, 100, 1500, 1, 0, 3'd2, h);
    h = mk(4, 4, 100, 64, UNI); run_one("R1 ihl<5", h, 100, 1500, 1, 0, 3'd2, h);
    h = mk(4, 5, 16, 64, UNI);  run_one("R1 short tot", h, 100, 1500, 1, 0, 3'd2, h);
    h = mk(4, 5, 200, 64, UNI); run_one("R1 tot>frame", h, 100, 1500, 1, 0, 3'd2, h);
  endtask

  task automatic t_options();
    logic [159:0] h;
    h = mk(4, 6, 100, 64, UNI); run_one("R2 options", h, 100, 1500, 1, 0, 3'd3, h);
    h = mk(5, 6, 100, 64, UNI); run_one("R9 bad before opt", h, 100, 1500, 1, 0, 3'd2, h);
  endtask

  task automatic t_mcast();
    logic [159:0] h = mk(4, 5, 100, 64, 32'hE0000001);
    run_one("R3 mcast", h, 100, 1500, 1, 0, 3'd5, h);
    run_one("R9 mcast before local", h, 100, 1500, 1, 1, 3'd5, h);
  endtask

  task automatic t_miss();
    logic [159:0] h = mk(4, 5, 100, 64, UNI);
    run_one("R5 miss", h, 100, 1500, 0, 0, 3'd6, h);
    h = mk(4, 5, 100, 1, UNI);
    run_one("R9 miss before ttl", h, 100, 1500, 0, 0, 3'd6, h);
  endtask

  task automatic t_ttl();
    logic [159:0] h;
    h = mk(4, 5, 100, 1, UNI); run_one("R6 ttl1", h, 100, 1500, 1, 0, 3'd4, h);
    h = mk(4, 5, 100, 0, UNI); run_one("R6 ttl0", h, 100, 1500, 1, 0, 3'd4, h);
  endtask

  task automatic t_frag();
    logic [159:0] h = mk(4, 5, 100, 64, UNI);
    run_one("R7 frag", h, 100, 99, 1, 0, 3'd7, h);
    run_one("R7 mtu equal", h, 100, 100, 1, 0, 3'd0, fwd_exp(h));
  endtask

  task automatic t_stream();
    logic [159:0] hs [3];
    hs[0] = mk(4, 5, 60, 10, UNI);
    hs[1] = mk(4, 5, 80, 20, 32'h0b000003);
    hs[2] = mk(4, 5, 90, 30, 32'h0c000004);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R10 stream valid", 160'(valid_o), 160'd1);
        chk("R10 stream hdr", hdr_o, fwd_exp(hs[i-2]));
        chk("R10 stream nh", 160'(next_hop_o), 160'(i - 2 + 16));
      end
      if (i < 3) drive(hs[i], 100, 1500, 1, 0, NH_W'(i + 16));
      else valid_i = 1'b0;
    end
    @(negedge clk);
    chk("R10 stream drained", 160'(valid_o), 160'd0);
  endtask

  task automatic t_stall();
    logic [159:0] a = mk(4, 5, 40, 9, UNI);
    logic [159:0] b = mk(4, 5, 44, 33, UNI);
    @(negedge clk); ready_i = 1'b0; drive(a, 100, 1500, 1, 0, 8'h01);
    @(negedge clk); drive(b, 100, 1500, 1, 0, 8'h02);
    @(negedge clk); valid_i = 1'b0;
    chk("R11 ready_o low", 160'(ready_o), 160'd0);
    chk("R11 first out", hdr_o, fwd_exp(a));
    @(negedge clk);
    @(negedge clk);
    chk("R11 hold hdr", hdr_o, fwd_exp(a));
    chk("R11 hold nh", 160'(next_hop_o), 160'h01);
    ready_i = 1'b1;
    @(negedge clk);
    chk("R11 second out", hdr_o, fwd_exp(b));
    chk("R11 second nh", 160'(next_hop_o), 160'h02);
    @(negedge clk);
    chk("R11 drained", 160'(valid_o), 160'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_local();
    t_malformed();
    t_options();
    t_mcast();
    t_miss();
    t_ttl();
    t_frag();
    t_stream();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      repeat (200000) @(posedge clk);
    join_any
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule